// File: doc/BRIEF.md
# Exception Entry Sequencer

This block starts exception handling for a 32-bit core. A fault or trap request arrives with a two-bit source code. The sequencer then takes a snapshot of the current program counter, stack pointer and status word, and writes a fixed two-store frame to the stack through a simple write port that waits on a ready signal. The first store is the PC as a word and the second is the status word as a halfword. When the second store is accepted, the block publishes a new stack pointer, a new status word with interrupts disabled, the fixed handler vector as the new PC, and an internal cause code. One cycle later it pulses `done` for one cycle.

Once an entry has completed, it stays marked as pending until the `resume` input is asserted. A new request that arrives while an entry is pending, or while the sequence is still running, raises the `nested` warning flag. A request that arrives during a running sequence is otherwise dropped. The surrounding core applies the published `new_*` values when `done` pulses.

Top module: `exc_entry_seq`

## Requirements
- R1: On an accepted request the first store presents address SP−4, data equal to the PC, and size code 2 (word), with `mem_wstrobe` high from the cycle after the request.
- R2: After the word store is accepted, the next store presents address SP−8, data equal to the status word zero-extended as it was before any change, and size code 1 (halfword).
- R3: Each store keeps `mem_wstrobe` high with unchanged address, data and size until it is sampled together with `mem_wready`. The strobe drops only after the halfword store is accepted.
- R4: On completion `new_sp` equals the snapshot SP minus 8, with 32-bit wraparound, and `new_psw` equals the snapshot status word with bit IE_BIT (default 11) cleared and all other bits kept.
- R5: On completion `new_pc` equals the vector 0x40000008.
- R6: On completion `cause` takes a value from the request source: source 0 (unmapped access) gives 1, source 1 (misaligned access) gives 2, source 2 (breakpoint) gives 3, and source 3 (illegal opcode) gives 4.
- R7: `done` is high for exactly one cycle, the cycle after the `new_*` outputs and `cause` are updated.
- R8: A request that arrives while a sequence is running does not change that sequence's stores or results, and it sets `nested`.
- R9: A completed entry marks an exception as pending, and a request that arrives while an entry is pending sets `nested`.
- R10: Asserting `resume` clears the pending mark and `nested`. If a request arrives in the same cycle, the request still sets `nested`.
- R11: After synchronous reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_src | input | 2 | Request source: 0 unmapped, 1 misaligned, 2 breakpoint, 3 illegal |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_sp | input | 32 | Current stack pointer |
| cur_psw | input | 16 | Current status word |
| resume | input | 1 | Clears the pending mark and the nested flag |
| mem_wready | input | 1 | Memory accepts the presented store |
| mem_addr | output | 32 | Store address |
| mem_wdata | output | 32 | Store data |
| mem_size | output | 2 | Store size: 1 halfword, 2 word |
| mem_wstrobe | output | 1 | Store request |
| new_sp | output | 32 | Stack pointer after entry |
| new_psw | output | 16 | Status word after entry |
| new_pc | output | 32 | Handler vector |
| cause | output | 3 | Recorded cause code |
| done | output | 1 | One-cycle completion pulse |
| nested | output | 1 | Nested-exception warning |

## Verification
The properties assume that `mem_wready` is only meaningful while a store is strobed, and that `req_valid`, `resume` and the snapshot inputs are synchronous and settled before each rising edge. The stimulus changes every input only on falling edges, so this assumption always holds. Ready is held low for zero to several cycles per store, so that both the immediate-accept path and the stall path are exercised. The hold property compares consecutive cycles, so it relies on the design never re-presenting a store after it has been accepted.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORD = 2'd1,
    ST_HALF = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;

  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int PC_SLOT_OFS = 4;
  localparam int FRAME_BYTES = 8;

  function automatic logic [2:0] src_to_cause(input logic [1:0] src);
    return {1'b0, src} + 3'd1;
  endfunction
endpackage

// File: rtl/exc_frame_gen.sv
module exc_frame_gen #(
  parameter int ADDR_W = 32,
  parameter int PSW_W  = 16
) (
  input  logic              half_sel,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] sp,
  input  logic [PSW_W-1:0]  psw,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] data,
  output logic [1:0]        size
);
  import exc_seq_pkg::*;

  localparam logic [ADDR_W-1:0] OFS_PC  = ADDR_W'(PC_SLOT_OFS);
  localparam logic [ADDR_W-1:0] OFS_PSW = ADDR_W'(FRAME_BYTES);
  localparam int PAD_W = ADDR_W - PSW_W;

  always_comb begin
    if (half_sel) begin
      addr = sp - OFS_PSW;
      data = {{PAD_W{1'b0}}, psw};
      size = SZ_HALF;
    end else begin
      addr = sp - OFS_PC;
      data = pc;
      size = SZ_WORD;
    end
  end
endmodule

// File: rtl/exc_nest_track.sv
module exc_nest_track (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic busy,
  input  logic complete,
  input  logic resume,
  output logic nested
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      nested  <= 1'b0;
    end else begin
      if (complete)
        pending <= 1'b1;
      else if (resume)
        pending <= 1'b0;

      if (req_valid && (pending || busy))
        nested <= 1'b1;
      else if (resume)
        nested <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int                ADDR_W = 32,
  parameter int                PSW_W  = 16,
  parameter int                IE_BIT = 11,
  parameter logic [ADDR_W-1:0] VECTOR = 32'h4000_0008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_src,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [PSW_W-1:0]  cur_psw,
  input  logic              resume,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  output logic [1:0]        mem_size,
  output logic              mem_wstrobe,
  output logic [ADDR_W-1:0] new_sp,
  output logic [PSW_W-1:0]  new_psw,
  output logic [ADDR_W-1:0] new_pc,
  output logic [2:0]        cause,
  output logic              done,
  output logic              nested
);
  import exc_seq_pkg::*;

  localparam logic [PSW_W-1:0]  IE_MASK  = PSW_W'(1) << IE_BIT;
  localparam logic [ADDR_W-1:0] SP_DEC   = ADDR_W'(FRAME_BYTES);

  seq_state_t        state;
  logic [ADDR_W-1:0] snap_pc, snap_sp;
  logic [PSW_W-1:0]  snap_psw;
  logic [2:0]        snap_cause;

  logic              idle;
  logic [ADDR_W-1:0] g_pc, g_sp, f_addr, f_data;
  logic [PSW_W-1:0]  g_psw;
  logic [1:0]        f_size;
  logic              finish;

  assign idle   = (state == ST_IDLE);
  assign g_pc   = idle ? cur_pc  : snap_pc;
  assign g_sp   = idle ? cur_sp  : snap_sp;
  assign g_psw  = idle ? cur_psw : snap_psw;
  assign finish = (state == ST_HALF) && mem_wready;

  exc_frame_gen #(.ADDR_W(ADDR_W), .PSW_W(PSW_W)) u_frame (
    .half_sel (!idle),
    .pc       (g_pc),
    .sp       (g_sp),
    .psw      (g_psw),
    .addr     (f_addr),
    .data     (f_data),
    .size     (f_size)
  );

  exc_nest_track u_nest (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (!idle),
    .complete  (finish),
    .resume    (resume),
    .nested    (nested)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      snap_pc     <= '0;
      snap_sp     <= '0;
      snap_psw    <= '0;
      snap_cause  <= '0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_size    <= '0;
      mem_wstrobe <= 1'b0;
      new_sp      <= '0;
      new_psw     <= '0;
      new_pc      <= '0;
      cause       <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            snap_pc     <= cur_pc;
            snap_sp     <= cur_sp;
            snap_psw    <= cur_psw;
            snap_cause  <= src_to_cause(req_src);
            mem_addr    <= f_addr;
            mem_wdata   <= f_data;
            mem_size    <= f_size;
            mem_wstrobe <= 1'b1;
            state       <= ST_WORD;
          end
        end
        ST_WORD: begin
          if (mem_wready) begin
            mem_addr  <= f_addr;
            mem_wdata <= f_data;
            mem_size  <= f_size;
            state     <= ST_HALF;
          end
        end
        ST_HALF: begin
          if (mem_wready) begin
            mem_wstrobe <= 1'b0;
            new_sp      <= snap_sp - SP_DEC;
            new_psw     <= snap_psw & ~IE_MASK;
            new_pc      <= VECTOR;
            cause       <= snap_cause;
            state       <= ST_FIN;
          end
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int                ADDR_W = 32,
  parameter int                PSW_W  = 16,
  parameter int                IE_BIT = 11,
  parameter logic [ADDR_W-1:0] VECTOR = 32'h4000_0008
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              resume,
  input logic              mem_wready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic [1:0]        mem_size,
  input logic              mem_wstrobe,
  input logic [PSW_W-1:0]  new_psw,
  input logic [ADDR_W-1:0] new_pc,
  input logic              done,
  input logic              nested
);
  assert_store_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wstrobe && !mem_wready) |=> (mem_wstrobe && $stable(mem_addr)
                                      && $stable(mem_wdata) && $stable(mem_size)));

  assert_strobe_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wstrobe && !$past(mem_wstrobe) && !$past(rst)) |-> mem_size == 2'd2);

  assert_half_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_wstrobe && mem_wready && mem_size == 2'd2) |=>
      (mem_wstrobe && mem_size == 2'd1 && mem_addr == $past(mem_addr) - ADDR_W'(4)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_vector_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (new_pc == VECTOR && !new_psw[IE_BIT]));

  assert_busy_nested_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mem_wstrobe) |=> nested);

  assert_resume_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (resume && !req_valid) |=> !nested);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .ADDR_W(ADDR_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT), .VECTOR(VECTOR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .resume      (resume),
  .mem_wready  (mem_wready),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_size    (mem_size),
  .mem_wstrobe (mem_wstrobe),
  .new_psw     (new_psw),
  .new_pc      (new_pc),
  .done        (done),
  .nested      (nested)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_src = 2'd0;
  logic [31:0] cur_pc = '0, cur_sp = '0;
  logic [15:0] cur_psw = '0;
  logic        resume = 1'b0;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, new_sp, new_pc;
  logic [1:0]  mem_size;
  logic        mem_wstrobe, done, nested;
  logic [15:0] new_psw;
  logic [2:0]  cause;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_psw(cur_psw), .resume(resume),
    .mem_wready(mem_wready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_size(mem_size), .mem_wstrobe(mem_wstrobe), .new_sp(new_sp),
    .new_psw(new_psw), .new_pc(new_pc), .cause(cause), .done(done),
    .nested(nested)
  );

  localparam int NV = 5;
  localparam logic [1:0]  T_SRC  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
  localparam logic [31:0] T_PC   [NV] = '{32'h0000_1000, 32'h1234_5678,
                                          32'hDEAD_BEEC, 32'h4000_0010, 32'hFFFF_FFFE};
  localparam logic [31:0] T_SP   [NV] = '{32'h0010_0000, 32'h0000_FFF0,
                                          32'h0000_0004, 32'h8000_0000, 32'h0000_0008};
  localparam logic [15:0] T_PSW  [NV] = '{16'h0800, 16'hFFFF, 16'h0000, 16'hF7FF, 16'h0A5A};
  localparam int          T_WAIT [NV] = '{0, 2, 1, 3, 0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_resume();
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
  endtask

  task automatic run_entry(input logic [1:0] src, input logic [31:0] pc,
                           input logic [31:0] sp, input logic [15:0] psw,
                           input int waits, input bit inject);
    req_valid = 1'b1; req_src = src; cur_pc = pc; cur_sp = sp; cur_psw = psw;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 word strobe", 32'(mem_wstrobe), 32'd1);
    chk("R1 word addr", mem_addr, sp - 32'd4);
    chk("R1 word data", mem_wdata, pc);
    chk("R1 word size", 32'(mem_size), 32'd2);
    if (inject) begin
      req_valid = 1'b1; req_src = ~src; cur_pc = ~pc; cur_sp = ~sp; cur_psw = ~psw;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 nested on busy request", 32'(nested), 32'd1);
      chk("R8 word addr kept", mem_addr, sp - 32'd4);
      chk("R8 word data kept", mem_wdata, pc);
    end
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk("R3 word held", mem_addr, sp - 32'd4);
      chk("R3 word strobe held", 32'(mem_wstrobe), 32'd1);
    end
    mem_wready = 1'b1;
    @(negedge clk);
    mem_wready = 1'b0;
    chk("R2 half strobe", 32'(mem_wstrobe), 32'd1);
    chk("R2 half addr", mem_addr, sp - 32'd8);
    chk("R2 half data", mem_wdata, {16'h0, psw});
    chk("R2 half size", 32'(mem_size), 32'd1);
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      chk("R3 half held", mem_wdata, {16'h0, psw});
      chk("R3 half strobe held", 32'(mem_wstrobe), 32'd1);
    end
    mem_wready = 1'b1;
    @(negedge clk);
    mem_wready = 1'b0;
    chk("R3 strobe dropped", 32'(mem_wstrobe), 32'd0);
    chk("R4 new sp", new_sp, sp - 32'd8);
    chk("R4 new psw", 32'(new_psw), 32'(psw & 16'hF7FF));
    chk("R5 new pc", new_pc, 32'h4000_0008);
    chk("R6 cause", 32'(cause), 32'(src) + 32'd1);
    chk("R7 done not yet", 32'(done), 32'd0);
    @(negedge clk);
    chk("R7 done high", 32'(done), 32'd1);
    @(negedge clk);
    chk("R7 done low again", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset strobe", 32'(mem_wstrobe), 32'd0);
    chk("R11 reset new pc", new_pc, 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset nested", 32'(nested), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pulse_resume();
      run_entry(T_SRC[i], T_PC[i], T_SP[i], T_PSW[i], T_WAIT[i], 1'b0);
      chk("R10 no nested after resume", 32'(nested), 32'd0);
    end

    // R9: request while previous entry pending
    run_entry(2'd2, 32'h0000_2000, 32'h0000_0100, 16'h0801, 0, 1'b0);
    chk("R9 nested when pending", 32'(nested), 32'd1);
    pulse_resume();
    chk("R10 resume clears nested", 32'(nested), 32'd0);

    // R8: request during running sequence ignored
    run_entry(2'd1, 32'h0000_3000, 32'h0000_0200, 16'h1800, 1, 1'b1);
    chk("R8 nested persists", 32'(nested), 32'd1);
    pulse_resume();
    chk("R10 resume clears busy nested", 32'(nested), 32'd0);

    // R10: resume with simultaneous request keeps nested (pending set by entry above)
    run_entry(2'd3, 32'h0000_4000, 32'h0000_0300, 16'h0000, 0, 1'b0);
    resume = 1'b1; req_valid = 1'b1; req_src = 2'd0;
    cur_pc = 32'h0000_5000; cur_sp = 32'h0000_0400; cur_psw = 16'h0800;
    @(negedge clk);
    resume = 1'b0; req_valid = 1'b0;
    chk("R10 request wins over resume", 32'(nested), 32'd1);
    mem_wready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mem_wready = 1'b0;
    chk("R5 vector after collision", new_pc, 32'h4000_0008);
    chk("R4 sp after collision", new_sp, 32'h0000_03F8);
    repeat (2) @(negedge clk);

    // R11: reset mid-sequence
    req_valid = 1'b1; cur_sp = 32'h0000_1000;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset clears strobe", 32'(mem_wstrobe), 32'd0);
    chk("R11 reset clears nested", 32'(nested), 32'd0);
    chk("R11 reset clears sp", new_sp, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule